// File: doc/BRIEF.md
# Triggered Fixed-Count Serial Clock Burst Generator

This block produces a serial clock that runs only on demand. A rising edge on the trigger input starts a burst of exactly `PULSES` clock pulses. Each pulse is high for `HIGH_CYC` system cycles and low for the remainder of a `PERIOD`-cycle period. After the last low phase the block stops and waits for the next trigger. It acts as a one-shot PWM with a repetition count. A frame timer elsewhere on the chip supplies the trigger, so the burst always has a fixed phase relative to each frame. Chip-select generation and data capture belong to other blocks.

The `arm` input gates the trigger. While it is low, no burst can start. Arming the block before the frame timer starts keeps it from emitting a stray first pulse. Only a fresh rising edge starts a burst, so a trigger that is already high when the block is armed does not start one.

The control is a three-state machine:
- `ST_IDLE`: the clock is low and busy is low.
- `ST_HIGH`: the clock is high.
- `ST_LOW`: the clock is low and busy is still high.

The transitions are:
- idle-to-high on an armed trigger edge (start).
- high-to-low when the high phase expires.
- low-to-high when the low phase expires and pulses remain (repeat).
- low-to-idle when the low phase of the final pulse expires (finish).

Top module: `burst_clk_gen`

## Requirements
- R1: After reset, `sclk` and `busy` are both low.
- R2: A 0-to-1 change of `trig` sampled at a clock edge, with `arm` high and the block idle, makes `busy` and `sclk` high from that edge onward. They are seen high in the cycle after the trigger.
- R3: Each burst contains exactly `PULSES` rising edges of `sclk`.
- R4: Every high phase of `sclk` lasts exactly `HIGH_CYC` system cycles.
- R5: Every low phase inside a burst, including the last one, lasts `PERIOD - HIGH_CYC` cycles. `busy` falls at the end of the final low phase.
- R6: A trigger edge that arrives while `busy` is high is ignored. It neither restarts nor extends the burst, so `busy` stays high for exactly `PULSES * PERIOD` cycles.
- R7: With `arm` low, trigger edges start nothing. A `trig` that is already high when `arm` rises starts nothing until it goes low and rises again.
- R8: `sclk` is low whenever `busy` is low.
- R9: A trigger edge sampled in the first idle cycle after a burst starts a new burst at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Enables burst starts when high |
| trig | input | 1 | Burst request; its rising edge is used |
| sclk | output | 1 | Generated serial clock; idles low |
| busy | output | 1 | High from burst start until the final low phase ends |

## Verification
Some rules are checked by the assertions on every cycle:
- the start reaction to an armed edge;
- that a disarmed idle state never leaves idle;
- that a running phase is never cut short by a new trigger;
- that the pulse and phase counters stay inside their bounds;
- that the finish transition drops `busy`.

Other properties can only be shown by the bench scenarios, which measure each burst at the ports:
- the exact rising-edge count;
- the high and low lengths;
- the total busy length under extra triggers;
- the absence of bursts for disarmed or pre-held triggers;
- the immediate back-to-back restart.

// File: rtl/burst_pkg.sv
package burst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } burst_state_t;
endpackage

// File: rtl/trig_gate.sv
module trig_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic trig,
    output logic fire
);
    logic trig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig;
    end

    // fire only on a fresh rising edge while armed (R7)
    assign fire = arm && trig && !trig_q;
endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expire
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= '0;
        else if (run)     cnt <= cnt + 1'b1;
    end

    assign expire = run && (cnt == limit);

    // R4/R5: a running phase never overshoots its programmed length
    a_r4_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= limit));
endmodule

// File: rtl/pulse_counter.sv
module pulse_counter #(
    parameter int PULSES = 16,
    parameter int CW     = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);
    localparam logic [CW-1:0] LAST_IDX = CW'(PULSES - 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= '0;
        else if (clear)              cnt <= '0;
        else if (step && last)       cnt <= '0;
        else if (step)               cnt <= cnt + 1'b1;
    end

    assign last = (cnt == LAST_IDX);

    // R3: the pulse index never passes the last pulse
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_IDX);
endmodule

// File: rtl/burst_clk_gen.sv
module burst_clk_gen #(
    parameter int PULSES   = 16,
    parameter int PERIOD   = 125,
    parameter int HIGH_CYC = 62
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic trig,
    output logic sclk,
    output logic busy
);
    import burst_pkg::*;

    localparam int LOW_CYC = PERIOD - HIGH_CYC;
    localparam int TW      = $clog2(PERIOD + 1);
    localparam int CW      = $clog2(PULSES + 1);
    localparam logic [TW-1:0] HI_LIM = TW'(HIGH_CYC - 1);
    localparam logic [TW-1:0] LO_LIM = TW'(LOW_CYC - 1);

    burst_state_t state, state_nx;
    logic fire, start, ph_end, last_pulse, step, restart;
    logic [TW-1:0] lim;

    trig_gate u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (arm),
        .trig  (trig),
        .fire  (fire)
    );

    assign start   = fire && (state == ST_IDLE);
    assign lim     = (state == ST_HIGH) ? HI_LIM : LO_LIM;
    assign step    = (state == ST_LOW) && ph_end;
    assign restart = (state_nx != state);

    phase_timer #(.W(TW)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .run     (state != ST_IDLE),
        .limit   (lim),
        .expire  (ph_end)
    );

    pulse_counter #(.PULSES(PULSES), .CW(CW)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .step  (step),
        .last  (last_pulse)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start)  state_nx = ST_HIGH;
            ST_HIGH: if (ph_end) state_nx = ST_LOW;
            ST_LOW:  if (ph_end) state_nx = last_pulse ? ST_IDLE : ST_HIGH;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        sclk = (state == ST_HIGH);
        busy = (state != ST_IDLE);
    end

    // R2: an armed edge in idle starts a high phase on the next cycle
    a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && fire) |=> (busy && sclk));
    // R7: disarmed idle never leaves idle
    a_r7_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !arm) |=> (state == ST_IDLE));
    // R6: a low phase is never cut short by a trigger
    a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOW && !ph_end) |=> (state == ST_LOW));
    // R5: busy falls once the final low phase expires
    a_r5_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOW && ph_end && last_pulse) |=> !busy);
endmodule

// File: tb/sim_burst_clk_gen.sv
`timescale 1ns/1ps
module sim_burst_clk_gen;
    localparam int PULSES   = 16;
    localparam int PERIOD   = 125;
    localparam int HIGH_CYC = 62;
    localparam int LOW_CYC  = PERIOD - HIGH_CYC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 1'b0;
    logic trig = 1'b0;
    logic sclk, busy;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_q[$];
    int bursts = 0;
    int viol = 0;

    always #2 clk = ~clk;

    burst_clk_gen #(.PULSES(PULSES), .PERIOD(PERIOD), .HIGH_CYC(HIGH_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .arm(arm), .trig(trig), .sclk(sclk), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    // monitor: measures each burst and compares with the queued expectation
    logic pb = 1'b0, ps = 1'b0;
    int nr = 0, blen = 0, hl = 0, ll = 0, exp_n = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !pb) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected burst", 1, 0);
                    exp_n = 0;
                end else begin
                    exp_n = exp_q.pop_front();
                end
                nr = 0; blen = 0; hl = 0; ll = 0;
                chk(sclk, "R2 sclk high at burst start", int'(sclk), 1);
            end
            if (busy) begin
                blen++;
                if (sclk) begin
                    if (!ps || !pb) begin
                        nr++;
                        if (nr > 1) chk(ll == LOW_CYC, "R5 low phase", ll, LOW_CYC);
                        ll = 0; hl = 0;
                    end
                    hl++;
                end else begin
                    if (ps) chk(hl == HIGH_CYC, "R4 high phase", hl, HIGH_CYC);
                    ll++;
                end
            end
            if (!busy && pb) begin
                chk(ll == LOW_CYC, "R5 final low phase", ll, LOW_CYC);
                chk(nr == exp_n, "R3 rising edges", nr, exp_n);
                chk(blen == PULSES * PERIOD, "R6 busy length", blen, PULSES * PERIOD);
                bursts++;
            end
            if (!busy && sclk) viol++;
            pb = busy;
            ps = sclk;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        idle_cycles(3);
        chk(!sclk, "R1 sclk after reset", int'(sclk), 0);
        chk(!busy, "R1 busy after reset", int'(busy), 0);
        rst_n = 1'b1;
        idle_cycles(2);

        // R7: trigger pulses while disarmed
        trig = 1'b1; idle_cycles(2); trig = 1'b0; idle_cycles(300);
        chk(!busy, "R7 disarmed trigger ignored", int'(busy), 0);

        // R7: trig already high when arming
        trig = 1'b1; idle_cycles(3); arm = 1'b1; idle_cycles(300);
        chk(!busy, "R7 pre-held trigger ignored", int'(busy), 0);
        trig = 1'b0; idle_cycles(5);

        // R2 + R6: armed burst with extra triggers during it
        exp_q.push_back(PULSES);
        trig = 1'b1;
        @(negedge clk);
        chk(busy, "R2 busy one cycle after trigger", int'(busy), 1);
        trig = 1'b0;
        idle_cycles(400);
        trig = 1'b1; idle_cycles(2); trig = 1'b0;
        idle_cycles(700);
        trig = 1'b1; idle_cycles(5); trig = 1'b0;
        wait_idle();

        // R9: trigger in the first idle cycle, held high for many cycles
        exp_q.push_back(PULSES);
        trig = 1'b1;
        @(negedge clk);
        chk(busy, "R9 back-to-back start", int'(busy), 1);
        idle_cycles(50);
        wait_idle();
        idle_cycles(20);
        chk(!busy, "R6 held trigger gives one burst", int'(busy), 0);
        trig = 1'b0;
        idle_cycles(5);

        // R3: a third ordinary burst
        exp_q.push_back(PULSES);
        trig = 1'b1; idle_cycles(1); trig = 1'b0;
        wait_idle();
        idle_cycles(10);

        chk(exp_q.size() == 0, "R3 all expected bursts seen", exp_q.size(), 0);
        chk(bursts == 3, "R6 burst count", bursts, 3);
        chk(viol == 0, "R8 sclk low while idle", viol, 0);
        finish_run();
    end
endmodule